// File: doc/BRIEF.md
# Debug-Board Interrupt Expander Registers

This block gathers up to sixteen interrupt requests from peripherals on a debug board and presents them to a host processor as a single active-low, level-sensitive interrupt line. Each request is synchronised into the block's clock domain. A rising edge on a request latches a pending bit in a status word. A mask word chooses which pending bits may drive the parent line. A separate clear word wipes pending bits for as long as its bits are held at 1, and software then writes it back to 0.

The host reaches everything through a small synchronous bus: a select, a write strobe, a 3-bit word address and 16-bit data in each direction. Three fixed identification words and a version word let software confirm that the board is fitted before it touches the interrupt logic. At start-up, software typically clears the mask, pulses the clear word with all ones and then zero, and finally masks the sources it does not use.

Top module: `irq_expander_regs`

## Requirements
- R1: After reset the mask word reads 0xFFFF, the status and clear words read 0x0000, `rdata_o` is 0x0000 and `irq_n_o` is high.
- R2: Word address 0 reads 0xAAAA, address 1 reads 0x5555, address 2 reads 0xCAFE and address 3 reads the VERSION parameter (default 0x0102).
- R3: A read (`cs_i`=1, `we_i`=0) presents the addressed word on `rdata_o` after the next rising clock edge, and `rdata_o` then holds until the next read. Address 7 reads 0x0000.
- R4: A 0-to-1 change on `src_i[n]` sets status bit n at the third rising edge that samples the new level. A source that stays high does not set its bit again once the bit has been cleared.
- R5: While clear-word bit n (address 6) is 1, status bit n is forced to 0 from the edge after the write. This holds even when a rising edge arrives on source n in that time.
- R6: Once clear-word bit n is written back to 0, a later rising edge on source n sets status bit n again.
- R7: `irq_n_o` is low exactly when some status bit n is 1 and mask bit n (address 5) is 0. A mask bit of 1 keeps its source off the line.
- R8: Writes to addresses 0 to 4 and 7 have no effect. The identification words, the status word and the mask word keep their values.
- R9: The mask word (address 5) and the clear word (address 6) read back the last value written to them.
- R10: Status bit n (address 4) belongs to source n, for every n from 0 to 15, with bit 0 the least significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Interrupt requests from peripherals, asynchronous |
| cs_i | input | 1 | Bus select for this cycle |
| we_i | input | 1 | 1 = write, 0 = read, when selected |
| addr_i | input | 3 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| irq_n_o | output | 1 | Parent interrupt, active low, level |

## Verification
The hardest case to reach is a source edge that lands while its clear bit is still held. The edge has to pass the synchroniser in the same window in which the clear word is 1. If it does, the clear must win and the bit must not reappear after release, because the level has not changed again. The bench holds the clear word for several cycles and toggles the source inside that window. It then releases the clear, raises the source once more and expects the bit to return. A random phase then overlaps clear pulses, mask writes and source toggles in arbitrary cycles against a cycle-exact reference.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_ID0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ID1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ID2  = 3'd2;
  localparam logic [ADDR_W-1:0] A_VER  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd6;

  localparam logic [REG_W-1:0] ID_WORD0 = 16'hAAAA;
  localparam logic [REG_W-1:0] ID_WORD1 = 16'h5555;
  localparam logic [REG_W-1:0] ID_WORD2 = 16'hCAFE;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_READ,
    BUS_WRITE
  } bus_op_e;

  // clear dominates; otherwise a new edge sets, else hold
  function automatic logic [REG_W-1:0] status_next(
      input logic [REG_W-1:0] cur,
      input logic [REG_W-1:0] set,
      input logic [REG_W-1:0] clr);
    return (cur | set) & ~clr;
  endfunction

  function automatic logic any_pending(
      input logic [REG_W-1:0] stat,
      input logic [REG_W-1:0] msk);
    return |(stat & ~msk);
  endfunction

  function automatic logic [REG_W-1:0] read_word(
      input logic [ADDR_W-1:0] adr,
      input logic [REG_W-1:0]  stat,
      input logic [REG_W-1:0]  msk,
      input logic [REG_W-1:0]  clr,
      input logic [REG_W-1:0]  ver);
    logic [REG_W-1:0] w;
    unique case (adr)
      A_ID0:   w = ID_WORD0;
      A_ID1:   w = ID_WORD1;
      A_ID2:   w = ID_WORD2;
      A_VER:   w = ver;
      A_STAT:  w = stat;
      A_MASK:  w = msk;
      A_CLR:   w = clr;
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/irqx_status.sv
module irqx_status
  import irqx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);

  logic [W-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= W'(status_next(REG_W'(status_q), REG_W'(set_i), REG_W'(clr_i)));
  end

  assign status_o = status_q;

endmodule

// File: rtl/irqx_regfile.sv
module irqx_regfile
  import irqx_pkg::*;
#(
  parameter logic [REG_W-1:0] VERSION = 16'h0102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  status_i,
  output logic [REG_W-1:0]  mask_o,
  output logic [REG_W-1:0]  clr_o,
  output logic [REG_W-1:0]  rdata_o
);

  bus_op_e          op;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] clr_q;
  logic [REG_W-1:0] rdata_q;

  always_comb begin
    if (!cs_i)      op = BUS_IDLE;
    else if (we_i)  op = BUS_WRITE;
    else            op = BUS_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      clr_q  <= '0;
    end else if (op == BUS_WRITE) begin
      if (addr_i == A_MASK) mask_q <= wdata_i;
      if (addr_i == A_CLR)  clr_q  <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rdata_q <= '0;
    else if (op == BUS_READ)  rdata_q <= read_word(addr_i, status_i, mask_q, clr_q, VERSION);
  end

  assign mask_o  = mask_q;
  assign clr_o   = clr_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_expander_regs.sv
module irq_expander_regs
  import irqx_pkg::*;
#(
  parameter int               NUM_SRC     = 16,
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] VERSION     = 16'h0102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       src_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_n_o
);

  // named internal events, observed by the bound checker
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] status_w;
  logic [REG_W-1:0]   mask_w;
  logic [REG_W-1:0]   clr_w;
  logic               pending_w;

  irqx_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_i[NUM_SRC-1:0]),
    .rise_o  (rise_w)
  );

  irqx_status #(.W(NUM_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (rise_w),
    .clr_i    (clr_w[NUM_SRC-1:0]),
    .status_o (status_w)
  );

  irqx_regfile #(.VERSION(VERSION)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_i     (cs_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .status_i (REG_W'(status_w)),
    .mask_o   (mask_w),
    .clr_o    (clr_w),
    .rdata_o  (rdata_o)
  );

  assign pending_w = any_pending(REG_W'(status_w), mask_w);
  assign irq_n_o   = ~pending_w;

endmodule

// File: rtl/irqx_checker.sv
module irqx_checker #(
  parameter int NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_i,
  input logic               we_i,
  input logic [2:0]         addr_i,
  input logic [15:0]        rdata_o,
  input logic               irq_n_o,
  input logic [NUM_SRC-1:0] rise_w,
  input logic [NUM_SRC-1:0] status_w,
  input logic [15:0]        mask_w,
  input logic [15:0]        clr_w
);

  // a status bit only appears after a synchronised rising edge
  assert_status_from_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_w & ~$past(status_w) & ~$past(rise_w)) == '0));

  // a held clear bit keeps its status bit at zero
  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_w[NUM_SRC-1:0]) |=> ((status_w & $past(clr_w[NUM_SRC-1:0])) == '0));

  // an unmasked, uncleared edge drives the parent line low next cycle
  assert_edge_raises_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(rise_w & ~mask_w[NUM_SRC-1:0] & ~clr_w[NUM_SRC-1:0])) && !(cs_i && we_i)) |=> !irq_n_o);

  // the line only releases after a clear or a register write
  assert_irq_release_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n_o) |-> $past((|clr_w) || (cs_i && we_i)));

  // first identification word
  assert_id0_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && !we_i && addr_i == 3'd0) |=> (rdata_o == 16'hAAAA));

  // writes elsewhere leave the mask alone
  assert_mask_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && we_i && addr_i != 3'd5) |=> $stable(mask_w));

endmodule

bind irq_expander_regs irqx_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_i     (cs_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .irq_n_o  (irq_n_o),
  .rise_w   (rise_w),
  .status_w (status_w),
  .mask_w   (mask_w),
  .clr_w    (clr_w)
);

// File: tb/tb_irq_expander_regs.sv
`timescale 1ns/1ps
module tb_irq_expander_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_n;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_expander_regs dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .cs_i(cs), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
  );

  // ---------------- reference model ----------------
  logic [15:0] hist[$];
  logic [15:0] m_stat, m_mask, m_clr, m_rdata;

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return 16'hAAAA;
      3'd1: return 16'h5555;
      3'd2: return 16'hCAFE;
      3'd3: return 16'h0102;
      3'd4: return m_stat;
      3'd5: return m_mask;
      3'd6: return m_clr;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{16'h0, 16'h0, 16'h0};
      m_stat = '0; m_mask = 16'hFFFF; m_clr = '0; m_rdata = '0;
    end else begin
      logic [15:0] newedge;
      logic [15:0] old_clr;
      newedge = hist[1] & ~hist[2];
      old_clr = m_clr;
      if (cs && !we) m_rdata = m_read(addr);
      if (cs && we && addr == 3'd5) m_mask = wdata;
      if (cs && we && addr == 3'd6) m_clr = wdata;
      for (int b = 0; b < 16; b++) begin
        if (old_clr[b]) m_stat[b] = 1'b0;
        else if (newedge[b]) m_stat[b] = 1'b1;
      end
      hist.push_front(src);
      void'(hist.pop_back());
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 rdata vs model", rdata, m_rdata);
      check("R7 irq_n vs model", {15'd0, irq_n}, {15'd0, ~|(m_stat & ~m_mask)});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // ---------------- directed and random stimulus ----------------
  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n after reset", {15'd0, irq_n}, 16'h0001);
    check("R1 rdata after reset", rdata, 16'h0000);
    bus_rd(3'd5, v); check("R1 mask reset", v, 16'hFFFF);
    bus_rd(3'd4, v); check("R1 status reset", v, 16'h0000);
    bus_rd(3'd6, v); check("R1 clear reset", v, 16'h0000);
    // R2 identification
    bus_rd(3'd0, v); check("R2 id0", v, 16'hAAAA);
    bus_rd(3'd1, v); check("R2 id1", v, 16'h5555);
    bus_rd(3'd2, v); check("R2 id2", v, 16'hCAFE);
    bus_rd(3'd3, v); check("R2 version", v, 16'h0102);
    // R3 unmapped and hold
    bus_rd(3'd7, v); check("R3 unmapped", v, 16'h0000);
    bus_rd(3'd1, v); idle(3); check("R3 rdata holds", rdata, 16'h5555);
    // start-up sequence, R9 readback
    bus_wr(3'd5, 16'h0000);
    bus_rd(3'd5, v); check("R9 mask readback", v, 16'h0000);
    bus_wr(3'd6, 16'hFFFF);
    bus_rd(3'd6, v); check("R9 clear readback", v, 16'hFFFF);
    bus_wr(3'd6, 16'h0000);
    bus_wr(3'd5, 16'h001F);
    // R4 edge on masked source 0, R7 masked keeps line high
    @(negedge clk); src[0] = 1'b1;
    idle(4);
    bus_rd(3'd4, v); check("R4 status bit0 set", v, 16'h0001);
    check("R7 masked source keeps irq_n high", {15'd0, irq_n}, 16'h0001);
    // R7 unmasked source 8 pulls line low
    @(negedge clk); src[8] = 1'b1;
    idle(4);
    check("R7 unmasked source drives irq_n low", {15'd0, irq_n}, 16'h0000);
    // R8 writes to read-only words
    bus_wr(3'd4, 16'h0000);
    bus_wr(3'd0, 16'h1234);
    bus_wr(3'd7, 16'hFFFF);
    bus_rd(3'd4, v); check("R8 status kept", v, 16'h0101);
    bus_rd(3'd0, v); check("R8 id0 kept", v, 16'hAAAA);
    bus_rd(3'd5, v); check("R8 mask kept", v, 16'h001F);
    // R5 held clear beats a new edge on source 9
    bus_wr(3'd6, 16'h0300);
    @(negedge clk); src[9] = 1'b1;
    idle(5);
    bus_rd(3'd4, v); check("R5 cleared bits held at zero", v, 16'h0001);
    check("R5 irq_n released", {15'd0, irq_n}, 16'h0001);
    bus_wr(3'd6, 16'h0000);
    idle(4);
    // R4 steady high level does not re-set
    bus_rd(3'd4, v); check("R4 no re-set from steady level", v, 16'h0001);
    // R6 new edge after release sets again
    @(negedge clk); src[9] = 1'b0; src[8] = 1'b0;
    idle(3);
    @(negedge clk); src[9] = 1'b1;
    idle(4);
    bus_rd(3'd4, v); check("R6 edge after release sets", v, 16'h0201);
    // R10 walk every source
    src = '0;
    bus_wr(3'd5, 16'h0000);
    idle(3);
    for (int n = 0; n < 16; n++) begin
      bus_wr(3'd6, 16'hFFFF);
      bus_wr(3'd6, 16'h0000);
      @(negedge clk); src[n] = 1'b1;
      idle(4);
      bus_rd(3'd4, v); check($sformatf("R10 source %0d", n), v, 16'h0001 << n);
      @(negedge clk); src[n] = 1'b0;
      idle(3);
    end
    // random overlap of edges, clears and mask writes
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) src[$urandom_range(0, 15)] ^= 1'b1;
      cs = ($urandom_range(0, 1) == 1);
      we = ($urandom_range(0, 2) == 0);
      addr = 3'($urandom_range(0, 7));
      wdata = ($urandom_range(0, 1) == 1) ? 16'h0000 : 16'($urandom & $urandom);
    end
    @(negedge clk); cs = 1'b0; we = 1'b0;
    idle(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule